// File: doc/BRIEF.md
# Bidirectional Row Scan Pulse Generator

This block selects the rows of an active-matrix display one at a time, once per video line. A start token enters a chain of master/slave stages and moves along it on a half-period scan enable. Both halves of every stage serve as taps, so each tap stays high for two half-periods and overlaps its neighbour for one half-period. Every row output is the NAND-style combination of two adjacent taps. The row pulses therefore follow one another without overlapping, and each lasts one half-period.

A direction input, captured when the start pulse arrives, chooses whether the scan runs from the first row to the last or from the last row to the first. When the token reaches the far end of the chain, a one-cycle carry pulse goes out so that a further chain can be started. A start that arrives while a scan is running clears the chain and begins a new scan.

Top module: `row_scan_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no start, every bit of `row_o` is 0 and `carry_o` is 0.
- R2: With `dir_i`=0 at start, count the scan ticks (`scan_tick_i` high at a clock edge) after the start cycle. Row index n-2 (bit n-2 of `row_o`) is 1 from the edge of tick n until the edge of tick n+1, for n = 2 .. ROWS+1. At all other times no row is high.
- R3: With `dir_i`=1 at start, the timing is the same as R2, but tick n selects bit ROWS-1-(n-2). The scan runs from the last row to the first.
- R4: At most one bit of `row_o` is 1 in any clock cycle.
- R5: `carry_o` is 1 for exactly one clock cycle per frame. That cycle follows the edge of tick 2*floor((ROWS+2)/2) after the start.
- R6: A start clears the scan. In the cycle after the start no row is high, and the scan then restarts its tick count from zero. A tick in the same cycle as a start is ignored.
- R7: The direction is sampled only in the start cycle. A change of `dir_i` during a scan has no effect on `row_o`.
- R8: Scan ticks without any preceding start select no row and produce no carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_tick_i | input | 1 | Half-period scan enable, one clock wide |
| start_i | input | 1 | Loads the token and restarts the scan |
| dir_i | input | 1 | Scan direction: 0 first row to last, 1 last row to first |
| row_o | output | ROWS | Row-select pulses, at most one high |
| carry_o | output | 1 | One-cycle pulse when the token leaves the last stage |

## Verification
A start and a scan tick can arrive in the same cycle. The bench provokes this by raising both together, both at the beginning of a frame and in the middle of a running scan. The result is judged by requiring that the row sequence and the carry timing match a start issued on its own, with the coincident tick not counted. Restarts that arrive before the carry, and direction flips during a scan, are swept for both directions and for several tick spacings.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef enum logic {
    DIR_TOP_DOWN  = 1'b0,
    DIR_BOTTOM_UP = 1'b1
  } scan_dir_e;

  // number of master/slave stages needed to form a given number of rows
  function automatic int unsigned stages_for(input int unsigned rows);
    return (rows + 2) / 2;
  endfunction

endpackage

// File: rtl/rsg_token_feed.sv
module rsg_token_feed (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic feed_o,
  output logic clr_o,
  output logic en_even_o,
  output logic en_odd_o
);

  logic       phase_q, phase_d;
  logic [1:0] hold_q, hold_d;

  // next-state
  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    if (start_i) begin
      phase_d = 1'b0;
      hold_d  = 2'd2;
    end else if (tick_i) begin
      phase_d = ~phase_q;
      if (hold_q != 2'd0) hold_d = hold_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hold_q  <= 2'd0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
    end
  end

  assign feed_o    = (hold_q != 2'd0);
  assign clr_o     = start_i;
  assign en_even_o = tick_i & ~start_i & ~phase_q;
  assign en_odd_o  = tick_i & ~start_i &  phase_q;

  AST_EN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_even_o && en_odd_o)); // R4

  AST_FEED_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q == 2'd0 && !start_i) |=> (hold_q == 2'd0)); // R8

endmodule

// File: rtl/rsg_tap_chain.sv
module rsg_tap_chain #(
  parameter int unsigned TAPS = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_even_i,
  input  logic            en_odd_i,
  input  logic            feed_i,
  output logic [TAPS-1:0] tap_o
);

  logic [TAPS-1:0] tap_q;
  logic [TAPS-1:0] tap_d;

  // even taps are master halves, odd taps are slave halves
  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic src;
    logic upd;
    if (j == 0) begin : g_head
      assign src = feed_i;
    end else begin : g_body
      assign src = tap_q[j-1];
    end
    if ((j % 2) == 0) begin : g_master
      assign upd = en_even_i;
    end else begin : g_slave
      assign upd = en_odd_i;
    end
    assign tap_d[j] = clr_i ? 1'b0 : (upd ? src : tap_q[j]);

    if (j > 0) begin : g_chk
      AST_TAP_FROM_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tap_q[j]) |-> $past(tap_q[j-1])); // R2
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= '0;
    else         tap_q <= tap_d;
  end

  assign tap_o = tap_q;

endmodule

// File: rtl/rsg_row_gate.sv
module rsg_row_gate #(
  parameter int unsigned ROWS = 9,
  parameter int unsigned TAPS = 10
) (
  input  logic [TAPS-1:0] tap_i,
  input  rsg_pkg::scan_dir_e dir_i,
  output logic [ROWS-1:0] row_o
);

  logic [ROWS-1:0] pair_n;
  logic [ROWS-1:0] lrow;

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    // NAND of two adjacent taps, inverted toward the row line
    assign pair_n[k] = ~(tap_i[k] & tap_i[k+1]);
    assign lrow[k]   = ~pair_n[k];
    assign row_o[k]  = (dir_i == rsg_pkg::DIR_BOTTOM_UP) ? lrow[ROWS-1-k] : lrow[k];
  end

endmodule

// File: rtl/row_scan_gen.sv
module row_scan_gen #(
  parameter int unsigned ROWS = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scan_tick_i,
  input  logic            start_i,
  input  logic            dir_i,
  output logic [ROWS-1:0] row_o,
  output logic            carry_o
);

  localparam int unsigned STAGES = rsg_pkg::stages_for(ROWS);
  localparam int unsigned TAPS   = 2 * STAGES;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic            feed, clr, en_even, en_odd;
  logic [TAPS-1:0] tap;
  rsg_pkg::scan_dir_e dir_q, dir_d;
  logic            carry_q, carry_d;

  rsg_token_feed i_feed (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (start_i),
    .tick_i    (scan_tick_i),
    .feed_o    (feed),
    .clr_o     (clr),
    .en_even_o (en_even),
    .en_odd_o  (en_odd)
  );

  rsg_tap_chain #(.TAPS(TAPS)) i_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (clr),
    .en_even_i (en_even),
    .en_odd_i  (en_odd),
    .feed_i    (feed),
    .tap_o     (tap)
  );

  rsg_row_gate #(.ROWS(ROWS), .TAPS(TAPS)) i_gate (
    .tap_i (tap),
    .dir_i (dir_q),
    .row_o (row_o)
  );

  // direction captured at start; carry when the last tap is about to rise
  always_comb begin
    dir_d   = start_i ? rsg_pkg::scan_dir_e'(dir_i) : dir_q;
    carry_d = en_odd & tap[TAPS-2] & ~tap[TAPS-1];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= rsg_pkg::DIR_TOP_DOWN;
      carry_q <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      carry_q <= carry_d;
    end
  end

  assign carry_o = carry_q;

  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(row_o)); // R4

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (row_o == '0)); // R6

  AST_ROWS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!scan_tick_i && !start_i) |=> $stable(row_o)); // R7

  AST_CARRY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    carry_o |=> !carry_o); // R5

  AST_CARRY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_n)
    carry_o |-> $past(scan_tick_i)); // R5

endmodule

// File: tb/test_row_scan_gen.sv
`timescale 1ns/1ps
module test_row_scan_gen;

  localparam int ROWS = 9;
  localparam int TAPS = 2 * ((ROWS + 2) / 2);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, tick, start, dir;
  logic [ROWS-1:0] row;
  logic            carry;

  row_scan_gen #(.ROWS(ROWS)) i_row_scan_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scan_tick_i (tick),
    .start_i     (start),
    .dir_i       (dir),
    .row_o       (row),
    .carry_o     (carry)
  );

  int   n_chk  = 0;
  int   n_bad  = 0;
  int   m_cnt  = -1;
  logic m_dir  = 1'b0;
  logic exp_c  = 1'b0;
  bit   done   = 0;

  function automatic logic [ROWS-1:0] exp_rows(input int cnt, input logic d);
    logic [ROWS-1:0] v = '0;
    if (cnt >= 2 && cnt - 2 < ROWS) begin
      if (d) v[ROWS-1-(cnt-2)] = 1'b1;
      else   v[cnt-2]          = 1'b1;
    end
    return v;
  endfunction

  task automatic check(input string rq);
    logic [ROWS-1:0] er = exp_rows(m_cnt, m_dir);
    n_chk++;
    if (row !== er) begin
      n_bad++;
      $display("FAIL %s row_o actual=%b expected=%b", rq, row, er);
    end
    n_chk++;
    if (carry !== exp_c) begin
      n_bad++;
      $display("FAIL %s carry_o actual=%b expected=%b", rq, carry, exp_c);
    end
    n_chk++;
    if ($countones(row) > 1) begin  // R4
      n_bad++;
      $display("FAIL R4 row_o actual=%b expected at most one bit set", row);
    end
  endtask

  // one clock: drive at negedge, update model after the edge, check at next negedge
  task automatic cyc(input logic s, input logic t, input string rq);
    start = s;
    tick  = t;
    @(posedge clk);
    #1;
    if (s) begin
      m_cnt = 0;
      m_dir = dir;
    end else if (t && m_cnt >= 0) begin
      m_cnt++;
    end
    exp_c = !s && t && (m_cnt == TAPS);
    @(negedge clk);
    check(rq);
  endtask

  task automatic ticks(input int gap, input int n, input string rq);
    repeat (n) begin
      repeat (gap - 1) cyc(1'b0, 1'b0, rq);
      cyc(1'b0, 1'b1, rq);
    end
  endtask

  task automatic frame(input logic d, input int gap, input int n, input string rq);
    dir = d;
    cyc(1'b1, 1'b0, rq);
    ticks(gap, n, rq);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; start = 1'b0; dir = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b0, "R1");

    // R8: ticks with no start
    ticks(1, TAPS + 2, "R8");

    // R2 / R3 / R5: full frames in both directions, several tick spacings
    for (int g = 1; g <= 3; g++) begin
      frame(1'b0, g, TAPS + 3, "R2");
      frame(1'b1, g, TAPS + 3, "R3");
    end
    frame(1'b0, 2, TAPS + 3, "R5");

    // R6: restart mid-scan, and start coinciding with a tick
    for (int k = 1; k <= TAPS; k++) begin
      frame(k % 2, 1, k, "R6");
      frame(~(k % 2), 2, TAPS + 2, "R6");
    end
    dir = 1'b1;
    cyc(1'b1, 1'b1, "R6");
    ticks(1, 4, "R6");
    cyc(1'b1, 1'b1, "R6");
    ticks(2, TAPS + 2, "R6");

    // R7: flip direction during a scan
    for (int d = 0; d < 2; d++) begin
      dir = d[0];
      cyc(1'b1, 1'b0, "R7");
      ticks(1, 3, "R7");
      dir = ~dir;
      ticks(2, TAPS, "R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule